// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer with Dynamic Sizing

This block runs one memory bus transaction for each request from a processor core. A request gives an address, a direction, a size (byte or word) and write data. The sequencer steps the bus through four T states. The internal clock runs at twice the bus clock rate, so each T state lasts one internal clock. Wait states can be added at each of the three T-state boundaries. Each wait state lasts one bus clock, which is two internal clocks. At a boundary, the sequencer first spends a configured number of internal wait states and only then looks at the external active-low wait input. Memory uses its own request, read and write strobes, and only one transaction is on the bus at a time.

The addressed memory can report that it is only byte wide. If it does so during a word transfer, the sequencer keeps the low byte and at once runs a second transaction at the next address to fetch or store the high byte. The core sees a single completion pulse after the last bus transaction. That pulse carries read data assembled to full word width.

Top module: `mem_bus_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In idle, reqReady is 1, memReqN, memRdN and memWrN are 1, memWdataOe is 0 and doneValid is 0, including when reset arrives in the middle of a transaction.
- R2: With no wait states, a transaction is four internal clocks long (T1..T4) and memReqN is low for all four. memAddr holds the transaction address throughout. doneValid pulses in the clock after T4 of the last transaction.
- R3: cfgWait12, cfgWait23 and cfgWait34 (0..3 each) add that many internal wait states, at two clocks each, at the T1/T2, T2/T3 and T3/T4 boundaries respectively.
- R4: memWaitN is sampled at a boundary only after its internal wait states have finished. The sample point is the boundary's T-state clock when the count is 0, otherwise the last clock of the final internal wait state. Each low sample adds one more two-clock wait state, and the input is sampled again at its end. Low levels seen while internal waits are still running have no effect.
- R5: memRdN (reads) or memWrN (writes) is low from T2 through T4, including any wait states between T2 and T4. It is high during T1 and during T1/T2 waits. memWdataOe follows the write strobe. The two strobes are never low together.
- R6: Read data is captured from memRdata in the T4 clock only. A word read returns memRdata as is. A byte read returns the addressed byte zero-extended in doneRdata[7:0]. The byte lane is [7:0] for an even address and [15:8] for an odd address.
- R7: If memByteN is low in T4 of a word transaction, only the low byte is moved, on lane [7:0]. A second transaction then follows at once, with address+1, memWord=0 and the high byte on lane [15:8]. doneValid pulses only after the second transaction, and a read returns {second byte, first byte}.
- R8: memByteN has no effect during byte requests or during the second transaction of a split word.
- R9: reqReady is 1 only while idle, and a request is accepted in a clock where both reqValid and reqReady are 1. doneValid is a single-clock pulse.
- R10: Write data is driven on memWdata as follows: the whole word for a word transaction, and the data byte copied onto both lanes for a byte request or for the second transaction of a split word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Sequencer idle and able to accept a request |
| reqAddr | input | ADDR_W | Request address; word requests use an even address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word, 0 = byte |
| reqWdata | input | DATA_W | Write data; a byte write uses bits [7:0] |
| cfgWait12 | input | WAIT_W | Internal wait states at the T1/T2 boundary |
| cfgWait23 | input | WAIT_W | Internal wait states at the T2/T3 boundary |
| cfgWait34 | input | WAIT_W | Internal wait states at the T3/T4 boundary |
| doneValid | output | 1 | Single-clock completion pulse |
| doneRdata | output | DATA_W | Assembled read data, valid with doneValid |
| memAddr | output | ADDR_W | Memory address |
| memReqN | output | 1 | Active-low memory request strobe, T1 to T4 |
| memRdN | output | 1 | Active-low read strobe, T2 to T4 |
| memWrN | output | 1 | Active-low write strobe, T2 to T4 |
| memWord | output | 1 | Current transaction is word sized |
| memWdata | output | DATA_W | Write data bus |
| memWdataOe | output | 1 | Write data drive enable |
| memRdata | input | DATA_W | Read data bus from memory |
| memWaitN | input | 1 | Active-low external wait request |
| memByteN | input | 1 | Active-low byte-wide port indication |

## Verification
The hardest case to bring about is a low memWaitN that overlaps the internal wait window of a boundary. A design that samples too early would add wait states where none belong. The bench computes each boundary's sample points from the configured counts and its own chosen number of external waits. It holds memWaitN low from the start of the boundary's T state until just before the final sample, so every early look sees a low level. The split word path is reached by driving memByteN low during a word transfer. The bench puts random data on the unused lane and on memRdata outside T4, so that a wrong lane or a wrong capture clock shows up in the assembled result.

// File: rtl/mem_bus_seq_pkg.sv
package mem_bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4,
    ST_WAIT
  } tState_t;

  typedef enum logic [2:0] {
    CAP_NONE,
    CAP_WORD,
    CAP_LOW,
    CAP_HIGH,
    CAP_BYTE
  } capMode_t;

  typedef struct packed {
    logic     load;
    logic     upperHalf;
    capMode_t capMode;
  } dpCtrl_t;

endpackage

// File: rtl/mem_bus_seq_ctrl.sv
module mem_bus_seq_ctrl
  import mem_bus_seq_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [WAIT_W-1:0] cfgWait12,
  input  logic [WAIT_W-1:0] cfgWait23,
  input  logic [WAIT_W-1:0] cfgWait34,
  input  logic              memWaitN,
  input  logic              memByteN,
  input  logic              isWrite,
  input  logic              isWord,
  output dpCtrl_t           dpc,
  output logic              memReqN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              memWdataOe,
  output logic              memWord,
  output logic              doneValid
);

  tState_t           state, resume, bndNext;
  logic [WAIT_W-1:0] waitLeft, bndCfg;
  logic              halfPhase, upper, doneQ, dataPhase;

  always_comb begin
    case (state)
      ST_T1:   begin bndCfg = cfgWait12; bndNext = ST_T2; end
      ST_T2:   begin bndCfg = cfgWait23; bndNext = ST_T3; end
      default: begin bndCfg = cfgWait34; bndNext = ST_T4; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      resume    <= ST_IDLE;
      waitLeft  <= '0;
      halfPhase <= 1'b0;
      upper     <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_T1;
          upper <= 1'b0;
        end
        ST_T1, ST_T2, ST_T3: begin
          resume    <= bndNext;
          halfPhase <= 1'b0;
          if (bndCfg != '0) begin
            state    <= ST_WAIT;
            waitLeft <= bndCfg;
          end else if (!memWaitN) begin
            state    <= ST_WAIT;
            waitLeft <= '0;
          end else begin
            state <= bndNext;
          end
        end
        ST_WAIT: begin
          if (!halfPhase) begin
            halfPhase <= 1'b1;
          end else begin
            halfPhase <= 1'b0;
            if (waitLeft > WAIT_W'(1)) waitLeft <= waitLeft - WAIT_W'(1);
            else if (!memWaitN)        waitLeft <= '0;
            else                       state    <= resume;
          end
        end
        ST_T4: begin
          if (isWord && !upper && !memByteN) begin
            state <= ST_T1;
            upper <= 1'b1;
          end else begin
            state <= ST_IDLE;
            upper <= 1'b0;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dataPhase = (state == ST_T2) || (state == ST_T3) || (state == ST_T4) ||
                ((state == ST_WAIT) && (resume != ST_T2));
    reqReady      = (state == ST_IDLE);
    memReqN       = (state == ST_IDLE);
    memRdN        = !(dataPhase && !isWrite);
    memWrN        = !(dataPhase && isWrite);
    memWdataOe    = dataPhase && isWrite;
    memWord       = (state != ST_IDLE) && isWord && !upper;
    doneValid     = doneQ;
    dpc.load      = (state == ST_IDLE) && reqValid;
    dpc.upperHalf = upper;
    dpc.capMode   = CAP_NONE;
    if (state == ST_T4 && !isWrite) begin
      if (!isWord)        dpc.capMode = CAP_BYTE;
      else if (upper)     dpc.capMode = CAP_HIGH;
      else if (!memByteN) dpc.capMode = CAP_LOW;
      else                dpc.capMode = CAP_WORD;
    end
  end

  // R9: completion is a single-clock pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

  // R9: an accepted request starts the bus and drops ready
  p_accept_start_r9: assert property (@(posedge clk) disable iff (rst)
    (reqReady && reqValid) |=> (!memReqN && !reqReady));

  // R3: every wait state spans two clocks
  p_wait_full_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !halfPhase) |=> (state == ST_WAIT));

  // R4: pending internal waits continue whatever memWaitN does
  p_internal_first_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && halfPhase && waitLeft > WAIT_W'(1)) |=> (state == ST_WAIT));

  // R5: read and write strobes are exclusive
  p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!memRdN && !memWrN));

  // R7: no third transaction after the follow-on byte
  p_no_third_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T4 && upper) |=> (state == ST_IDLE));

endmodule

// File: rtl/mem_bus_seq_dp.sv
module mem_bus_seq_dp
  import mem_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isWrite,
  output logic              isWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] doneRdata
);

  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              writeQ, wordQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
    end else begin
      if (dpc.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
        wordQ  <= reqWord;
      end
      case (dpc.capMode)
        CAP_WORD: rdataQ <= memRdata;
        CAP_LOW:  rdataQ[BYTE_W-1:0] <= memRdata[BYTE_W-1:0];
        CAP_HIGH: rdataQ[DATA_W-1:BYTE_W] <= memRdata[DATA_W-1:BYTE_W];
        CAP_BYTE: rdataQ <= {{BYTE_W{1'b0}},
                             addrQ[0] ? memRdata[DATA_W-1:BYTE_W] : memRdata[BYTE_W-1:0]};
        default:  ;
      endcase
    end
  end

  assign memAddr   = dpc.upperHalf ? addrQ + ADDR_W'(1) : addrQ;
  assign isWrite   = writeQ;
  assign isWord    = wordQ;
  assign doneRdata = rdataQ;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    assign memWdata[ln*BYTE_W +: BYTE_W] =
      !wordQ        ? wdataQ[BYTE_W-1:0] :
      dpc.upperHalf ? wdataQ[DATA_W-1:BYTE_W] :
                      wdataQ[ln*BYTE_W +: BYTE_W];
  end

  // R2: the captured request stays put while a transaction runs
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !dpc.load |=> $stable(addrQ));

endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq
  import mem_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [WAIT_W-1:0] cfgWait12,
  input  logic [WAIT_W-1:0] cfgWait23,
  input  logic [WAIT_W-1:0] cfgWait34,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memReqN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              memWord,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWdataOe,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memWaitN,
  input  logic              memByteN
);

  dpCtrl_t dpc;
  logic    isWrite, isWord;

  mem_bus_seq_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .cfgWait12(cfgWait12), .cfgWait23(cfgWait23), .cfgWait34(cfgWait34),
    .memWaitN(memWaitN), .memByteN(memByteN), .isWrite(isWrite), .isWord(isWord),
    .dpc(dpc), .memReqN(memReqN), .memRdN(memRdN), .memWrN(memWrN),
    .memWdataOe(memWdataOe), .memWord(memWord), .doneValid(doneValid)
  );

  mem_bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .dpc(dpc), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqWdata(reqWdata), .memRdata(memRdata),
    .isWrite(isWrite), .isWord(isWord), .memAddr(memAddr),
    .memWdata(memWdata), .doneRdata(doneRdata)
  );

endmodule

// File: tb/mem_bus_seq_tb.sv
`timescale 1ns/1ps
module mem_bus_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqReady, reqWrite = 1'b0, reqWord = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  cfgWait12 = '0, cfgWait23 = '0, cfgWait34 = '0;
  logic        doneValid, memReqN, memRdN, memWrN, memWord, memWdataOe;
  logic [15:0] doneRdata, memAddr, memWdata;
  logic [15:0] memRdata = '0;
  logic        memWaitN = 1'b1, memByteN = 1'b1;

  logic [7:0] mem [0:255];
  int total = 0, bad = 0, extMax = 0;

  always #2.5 clk = ~clk;

  mem_bus_seq u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWord(reqWord), .reqWdata(reqWdata),
    .cfgWait12(cfgWait12), .cfgWait23(cfgWait23), .cfgWait34(cfgWait34),
    .doneValid(doneValid), .doneRdata(doneRdata), .memAddr(memAddr),
    .memReqN(memReqN), .memRdN(memRdN), .memWrN(memWrN), .memWord(memWord),
    .memWdata(memWdata), .memWdataOe(memWdataOe), .memRdata(memRdata),
    .memWaitN(memWaitN), .memByteN(memByteN)
  );

  task automatic chk(input logic ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic waitLevel(input int k, input int s2, input int s3,
                                     input int w12, input int w23, input int w34,
                                     input int e1, input int e2, input int e3);
    logic low;
    low = (k < 2*w12 + 2*e1) ||
          (k >= s2 && k < s2 + 2*w23 + 2*e2) ||
          (k >= s3 && k < s3 + 2*w34 + 2*e3);
    return !low;
  endfunction

  task automatic doReq(input logic [15:0] a, input logic wr, input logic wd,
                       input logic [15:0] wdat, input logic splitPlan,
                       input logic [1:0] w12, input logic [1:0] w23, input logic [1:0] w34);
    int nSub;
    logic [15:0] expRd;
    cfgWait12 = w12; cfgWait23 = w23; cfgWait34 = w34;
    reqAddr = a; reqWrite = wr; reqWord = wd; reqWdata = wdat; reqValid = 1'b1;
    chk(reqReady == 1'b1, "R9 ready while idle", {31'b0, reqReady}, 1);
    @(negedge clk);
    reqValid = 1'b0;
    nSub = (wd && splitPlan) ? 2 : 1;
    for (int sub = 0; sub < nSub; sub++) begin
      int e1, e2, e3, s2, s3, s4;
      logic [15:0] subAddr;
      logic bn;
      e1 = (extMax > 0) ? int'($urandom % (extMax + 1)) : 0;
      e2 = (extMax > 0) ? int'($urandom % (extMax + 1)) : 0;
      e3 = (extMax > 0) ? int'($urandom % (extMax + 1)) : 0;
      s2 = 2*w12 + 2*e1 + 1;
      s3 = s2 + 2*w23 + 2*e2 + 1;
      s4 = s3 + 2*w34 + 2*e3 + 1;
      subAddr = a + 16'(sub);
      bn = (wd && sub == 0) ? !splitPlan : 1'($urandom % 2); // R8: random on byte txns
      for (int k = 0; k <= s4; k++) begin
        memWaitN = waitLevel(k, s2, s3, w12, w23, w34, e1, e2, e3);
        memByteN = bn;
        memRdata = 16'($urandom);
        if (k == s4 && !wr) begin
          if (wd && sub == 0 && !splitPlan) memRdata = {mem[a[7:0]+8'd1], mem[a[7:0]]};
          else if (wd && sub == 0)          memRdata[7:0]  = mem[a[7:0]];
          else if (wd)                      memRdata[15:8] = mem[a[7:0]+8'd1];
          else if (a[0])                    memRdata[15:8] = mem[a[7:0]];
          else                              memRdata[7:0]  = mem[a[7:0]];
        end
        chk(memReqN == 1'b0, "R2 R3 R4 request strobe held", {31'b0, memReqN}, 0);
        chk(memAddr == subAddr, "R2 R7 address", {16'b0, memAddr}, {16'b0, subAddr});
        chk(memRdN == !(!wr && k >= s2), "R5 read strobe window", {31'b0, memRdN},
            {31'b0, !(!wr && k >= s2)});
        chk(memWrN == !(wr && k >= s2), "R5 write strobe window", {31'b0, memWrN},
            {31'b0, !(wr && k >= s2)});
        chk(memWdataOe == (wr && k >= s2), "R5 write data enable", {31'b0, memWdataOe},
            {31'b0, wr && k >= s2});
        chk(memWord == (wd && sub == 0), "R7 size output", {31'b0, memWord},
            {31'b0, wd && sub == 0});
        chk(doneValid == 1'b0 && reqReady == 1'b0, "R9 busy no done", {30'b0, doneValid, reqReady}, 0);
        if (k == s4 && wr) begin
          if (wd && sub == 0 && !splitPlan)
            chk(memWdata == wdat, "R10 word write data", {16'b0, memWdata}, {16'b0, wdat});
          else if (wd && sub == 0)
            chk(memWdata[7:0] == wdat[7:0], "R7 split low lane", {24'b0, memWdata[7:0]}, {24'b0, wdat[7:0]});
          else if (wd)
            chk(memWdata == {2{wdat[15:8]}}, "R7 R10 split high lane", {16'b0, memWdata}, {16'b0, {2{wdat[15:8]}}});
          else
            chk(memWdata == {2{wdat[7:0]}}, "R10 byte replicated", {16'b0, memWdata}, {16'b0, {2{wdat[7:0]}}});
        end
        @(negedge clk);
      end
    end
    memWaitN = 1'b1; memByteN = 1'b1;
    chk(doneValid == 1'b1, "R2 R7 done after last T4", {31'b0, doneValid}, 1);
    chk(memReqN == 1'b1, "R2 bus idle after T4", {31'b0, memReqN}, 1);
    if (!wr) begin
      expRd = wd ? {mem[a[7:0]+8'd1], mem[a[7:0]]} : {8'h00, mem[a[7:0]]};
      chk(doneRdata == expRd, "R6 R7 read data", {16'b0, doneRdata}, {16'b0, expRd});
    end else if (wd) begin
      mem[a[7:0]] = wdat[7:0];
      mem[a[7:0]+8'd1] = wdat[15:8];
    end else begin
      mem[a[7:0]] = wdat[7:0];
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(reqReady && memReqN && memRdN && memWrN && !memWdataOe && !doneValid,
        "R1 reset idle", {26'b0, reqReady, memReqN, memRdN, memWrN, memWdataOe, doneValid}, 6'b111100);
    rst = 1'b0;
    @(negedge clk);
    chk(doneValid == 1'b0, "R1 no done after reset", {31'b0, doneValid}, 0);

    // directed: R2 no waits, word write then read
    doReq(16'h0010, 1'b1, 1'b1, 16'hBEEF, 1'b0, 2'd0, 2'd0, 2'd0);
    doReq(16'h0010, 1'b0, 1'b1, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0);
    // R3: maximum internal waits, split write (R7) and both read styles
    doReq(16'h0020, 1'b1, 1'b1, 16'h1234, 1'b1, 2'd3, 2'd3, 2'd3);
    doReq(16'h0020, 1'b0, 1'b1, 16'h0000, 1'b0, 2'd1, 2'd2, 2'd3);
    doReq(16'h0020, 1'b0, 1'b1, 16'h0000, 1'b1, 2'd0, 2'd0, 2'd0);
    // R4: external waits overlapping internal ones
    extMax = 2;
    doReq(16'h0040, 1'b0, 1'b1, 16'h0000, 1'b0, 2'd2, 2'd0, 2'd1);
    // R6 R8 R10: byte lanes, odd and even, size-sense ignored
    doReq(16'h0031, 1'b1, 1'b0, 16'h77A5, 1'b0, 2'd0, 2'd1, 2'd0);
    doReq(16'h0031, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0);
    doReq(16'h0030, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0);

    for (int n = 0; n < 150; n++) begin
      logic wd;
      logic [15:0] a;
      wd = 1'($urandom % 2);
      a  = 16'($urandom % 254);
      if (wd) a[0] = 1'b0;
      doReq(a, 1'($urandom % 2), wd, 16'($urandom), 1'($urandom % 2),
            2'($urandom), 2'($urandom), 2'($urandom));
    end

    // R1: reset in the middle of a transaction
    cfgWait12 = 2'd3; reqAddr = 16'h0050; reqWrite = 1'b1; reqWord = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(reqReady && memReqN && memRdN && memWrN && !memWdataOe && !doneValid,
        "R1 mid-transaction reset", {26'b0, reqReady, memReqN, memRdN, memWrN, memWdataOe, doneValid}, 6'b111100);
    @(negedge clk);
    chk(doneValid == 1'b0 && memReqN == 1'b1, "R1 stays idle", {30'b0, doneValid, memReqN}, 1);
    finishUp();
  end

endmodule